// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs clause-22 management transactions between a host and an external PHY over a two-wire management interface (MDC clock, bidirectional MDIO data). Software loads one 32-bit command word into the frame register. Each field of the command sits at its wire position, so the word is sent exactly as written. Writing it starts a transaction. The controller first sends a preamble of 32 ones. It then shifts the 32 command bits out MSB first and toggles MDC at a rate set by the speed register.

For a read command (opcode `10`), the controller releases MDIO for the turnaround and data bits. It samples the 16 bits returned by the PHY and places them in the low half of the frame register; the upper half is unchanged. When the last bit ends, a completion flag is set. Software either polls it or enables it onto the interrupt output through a mask bit. A read that returns `0xFFFF` means no PHY answered, because an undriven MDIO line floats high.

Top module: `mdio_ctrl`

## Requirements
- R1: While reset is active and right after it, every register (frame, event, mask, speed) reads as zero, MDC is low, MDIO is not driven, and `irq_o` is low.
- R2: A transaction drives MDIO high for 32 MDC cycles. It then drives frame register bits 31 down to 0, one per MDC cycle. Each bit changes only when MDC falls, so it is stable across the rising edge.
- R3: The speed register is at word address 3 and holds a speed field in bits [SPD_W:1]. Each MDC half-period lasts that many system clocks. MDC rises for the first time one half-period after the start edge. MDC stays low when no transaction is running.
- R4: A write to the frame register (word address 0) starts a transaction only when the controller is idle and the speed field is non-zero. With a zero speed field the write is ignored: the frame register keeps its value and MDC does not toggle.
- R5: A write to the frame register while a transaction is running is ignored: the register contents and the bits being shifted do not change.
- R6: When frame bits [29:28] hold `10` (read), the MDIO output enable drops for the last 18 frame bits (turnaround and data) and stays low until the end. Any other opcode keeps MDIO driven for all 64 bit times.
- R7: For a read, MDIO is sampled on the MDC rising edge of each of the last 16 frame bits, first bit into bit 15. The result replaces frame bits [15:0] at completion, and bits [31:16] keep the command. An absent PHY yields `0xFFFF`.
- R8: Completion occurs at the 64th MDC falling edge, 128 x speed system clocks after the start edge. At that edge bit 0 of the event register (word address 1) is set.
- R9: The event register is write-one-to-clear. Writing 1 to bit 0 clears the flag, writing 0 leaves it unchanged, and a completion in the same cycle as a clear wins.
- R10: `irq_o` equals event bit 0 AND mask bit 0 (mask register at word address 2). With the mask at zero the completion can only be polled.
- R11: The speed field is latched when a transaction starts. Changing it mid-transaction affects only later transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address (0 frame, 1 event, 2 mask, 3 speed) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the register at `reg_addr_i` |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |
| irq_o | output | 1 | Masked completion interrupt |

## Verification
The tests send read commands to a present PHY address, a read to an absent address, and a write command. These separate the release of MDIO for turnaround and data from a fully driven frame, and they separate captured data from the idle-high `0xFFFF` result. The tests use speed values of 1, 2 and 3. These separate the half-period count from the toggle logic, and the odd value shows off-by-one errors in the divider. The tests also write during a transaction (frame and speed), write the frame register with a zero speed field, and write the event register with 0 and with all ones. These show whether the controller ignores stray commands, latches its rate at the start, and applies the clear rule correctly.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned TA_HI      = 17;
  localparam int unsigned REL_IDX    = FRAME_BITS - 1 - TA_HI;
  localparam int unsigned DATA_IDX   = FRAME_BITS - DATA_W;

  localparam logic [1:0] ADDR_FRAME = 2'd0;
  localparam logic [1:0] ADDR_EVT   = 2'd1;
  localparam logic [1:0] ADDR_MASK  = 2'd2;
  localparam logic [1:0] ADDR_SPEED = 2'd3;

  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRE   = 2'd1,
    PH_FRAME = 2'd2
  } phase_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned SPD_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [SPD_W-1:0] half_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam logic [SPD_W-1:0] ONE = SPD_W'(1);

  logic [SPD_W-1:0] half_q, cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == half_q - ONE);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= '0;
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
    end else if (start_i) begin
      // rate is frozen for the whole frame
      half_q <= half_i;
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REG_W-1:0]  cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              is_read_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] cap_o
);
  localparam int unsigned CNT_W = $clog2(PRE_BITS > FRAME_BITS ? PRE_BITS : FRAME_BITS);
  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] REL_AT     = CNT_W'(REL_IDX);
  localparam logic [CNT_W-1:0] CAP_AT     = CNT_W'(DATA_IDX);

  phase_e             ph_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [REG_W-1:0]   sh_q;
  logic               rd_q;
  logic [DATA_W-1:0]  cap_q;
  logic               in_frame, released, capture;

  assign in_frame  = (ph_q == PH_FRAME);
  assign released  = in_frame && rd_q && (cnt_q >= REL_AT);
  assign capture   = rise_i && in_frame && rd_q && (cnt_q >= CAP_AT);
  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = fall_i && in_frame && (cnt_q == FRAME_LAST);
  assign is_read_o = rd_q;
  assign mdio_o    = in_frame ? sh_q[REG_W-1] : 1'b1;
  assign mdio_oe_o = busy_o && !released;
  assign cap_o     = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      rd_q  <= 1'b0;
    end else if (start_i) begin
      ph_q  <= PH_PRE;
      cnt_q <= '0;
      sh_q  <= cmd_i;
      rd_q  <= (cmd_i[29:28] == OP_READ);
    end else if (fall_i) begin
      unique case (ph_q)
        PH_PRE: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == PRE_LAST) ph_q <= PH_FRAME;
        end
        PH_FRAME: begin
          cnt_q <= cnt_q + CNT_W'(1);
          sh_q  <= {sh_q[REG_W-2:0], 1'b0};
          if (cnt_q == FRAME_LAST) ph_q <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cap_q <= '0;
    else if (capture) cap_q <= {cap_q[DATA_W-2:0], mdio_i};
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int unsigned SPD_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              is_read_i,
  input  logic [DATA_W-1:0] cap_i,
  output logic              start_o,
  output logic [REG_W-1:0]  frame_o,
  output logic [SPD_W-1:0]  spd_o,
  output logic              evt_o,
  output logic              mask_o
);
  logic [REG_W-1:0] frame_q;
  logic [SPD_W-1:0] spd_q;
  logic             evt_q, mask_q;
  logic             wr_frame, wr_evt, wr_mask, wr_spd;

  assign wr_frame = wr_i && (addr_i == ADDR_FRAME);
  assign wr_evt   = wr_i && (addr_i == ADDR_EVT);
  assign wr_mask  = wr_i && (addr_i == ADDR_MASK);
  assign wr_spd   = wr_i && (addr_i == ADDR_SPEED);
  assign start_o  = wr_frame && !busy_i && (spd_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  frame_q <= '0;
    else if (start_o)             frame_q <= wdata_i;
    else if (done_i && is_read_i) frame_q[DATA_W-1:0] <= cap_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= 1'b0;
      mask_q <= 1'b0;
      spd_q  <= '0;
    end else begin
      if (done_i)                  evt_q <= 1'b1;
      else if (wr_evt && wdata_i[0]) evt_q <= 1'b0;
      if (wr_mask) mask_q <= wdata_i[0];
      if (wr_spd)  spd_q  <= wdata_i[SPD_W:1];
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_FRAME: rdata_o = frame_q;
      ADDR_EVT:   rdata_o = {{(REG_W-1){1'b0}}, evt_q};
      ADDR_MASK:  rdata_o = {{(REG_W-1){1'b0}}, mask_q};
      default:    rdata_o = {{(REG_W-SPD_W-1){1'b0}}, spd_q, 1'b0};
    endcase
  end

  assign frame_o = frame_q;
  assign spd_o   = spd_q;
  assign evt_o   = evt_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int unsigned SPD_W = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i,
  output logic        irq_o
);
  logic              start, busy, done, is_read, rise, fall;
  logic              evt_q, mask_q;
  logic [DATA_W-1:0] cap;
  logic [REG_W-1:0]  frame_q;
  logic [SPD_W-1:0]  spd;

  mdio_regs #(.SPD_W(SPD_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .done_i(done), .is_read_i(is_read), .cap_i(cap),
    .start_o(start), .frame_o(frame_q), .spd_o(spd), .evt_o(evt_q), .mask_o(mask_q)
  );

  mdio_clkgen #(.SPD_W(SPD_W)) u_clk (
    .clk_i, .rst_ni, .start_i(start), .run_i(busy), .half_i(spd),
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_engine u_eng (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(reg_wdata_i),
    .rise_i(rise), .fall_i(fall), .mdio_i,
    .busy_o(busy), .done_o(done), .is_read_o(is_read),
    .mdio_o, .mdio_oe_o, .cap_o(cap)
  );

  assign irq_o = evt_q & mask_q;
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        mdc_i,
  input logic        oe_i,
  input logic        evt_i,
  input logic        mask_i,
  input logic        irq_i,
  input logic [31:0] frame_i
);
  // R3
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i);
  // R6
  oe_stays_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !oe_i) |=> (!oe_i || !busy_i));
  // R8
  evt_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> evt_i);
  // R5
  frame_hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(frame_i));
  // R10
  irq_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> mask_i);
endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .mdc_i(mdc_o), .oe_i(mdio_oe_o),
  .evt_i(evt_q), .mask_i(mask_q), .irq_i(irq_o), .frame_i(frame_q)
);

// File: tb/mdio_ctrl_tb.sv
module mdio_ctrl_tb;
  localparam int SPD_W = 6;
  localparam logic [4:0] PHY_AT = 5'd5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i = 1'b1, irq;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  bit          m_busy = 0, m_read = 0, m_evt = 0, m_mask = 0;
  logic [31:0] m_frame = '0;
  int          m_spd = 0, h = 1, t = 0;

  always #10 clk = ~clk;

  mdio_ctrl #(.SPD_W(SPD_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mdc_o(mdc), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_i), .irq_o(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] phy_resp(input logic [31:0] f);
    if (f[27:23] == PHY_AT) return 16'h1234 ^ {11'd0, f[22:18]};
    return 16'hFFFF;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_frame;
      2'd1: return {31'd0, m_evt};
      2'd2: return {31'd0, m_mask};
      default: return 32'(m_spd) << 1;
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      m_busy = 0; m_evt = 0; m_mask = 0; m_frame = '0; m_spd = 0; t = 0;
    end else begin
      bit busy_before, done_now, clr;
      int b;
      bit e_mdc, e_oe, e_mdo;
      busy_before = m_busy; done_now = 0; clr = 0;
      if (m_busy) begin
        t++;
        if (t == 128 * h) begin m_busy = 0; done_now = 1; end
      end
      if (reg_wr) begin
        case (reg_addr)
          2'd0: if (!busy_before && m_spd != 0) begin
                  m_frame = reg_wdata; h = m_spd; m_busy = 1; t = 0;
                  m_read = (reg_wdata[29:28] == 2'b10);
                end
          2'd1: clr = reg_wdata[0];
          2'd2: m_mask = reg_wdata[0];
          default: m_spd = int'(reg_wdata[SPD_W:1]);
        endcase
      end
      if (done_now) begin
        m_evt = 1;
        if (m_read) m_frame[15:0] = phy_resp(m_frame);
      end else if (clr) m_evt = 0;

      b = t / (2 * h);
      e_mdc = m_busy && ((t / h) % 2 == 1);
      e_oe  = m_busy && !(m_read && b >= 46);
      e_mdo = (b < 32) ? 1'b1 : m_frame[31 - (b - 32)];
      check(mdc === e_mdc, "R3 mdc", 32'(mdc), 32'(e_mdc));
      check(mdio_oe === e_oe, "R6 oe", 32'(mdio_oe), 32'(e_oe));
      if (e_oe) check(mdio_o === e_mdo, "R2 mdio bit", 32'(mdio_o), 32'(e_mdo));
      check(irq === (m_evt & m_mask), "R10 irq", 32'(irq), 32'(m_evt & m_mask));
      check(reg_rdata === exp_rd(reg_addr), "R9 R7 rdata", reg_rdata, exp_rd(reg_addr));

      // PHY: answers reads at PHY_AT, line floats high otherwise
      mdio_i = 1'b1;
      if (m_busy && m_read && m_frame[27:23] == PHY_AT) begin
        if (b == 47) mdio_i = 1'b0;
        else if (b >= 48) mdio_i = phy_resp(m_frame)[15 - (b - 48)];
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic peek(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (m_busy && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] rd_cmd(input logic [4:0] pa, input logic [4:0] ra);
    return 32'h6002_0000 | (32'(pa) << 23) | (32'(ra) << 18);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      check(reg_rdata === 32'd0, "R1 reset reg", reg_rdata, 32'd0);
    end
    check({mdc, mdio_oe, irq} === 3'b000, "R1 reset pins", 32'({mdc, mdio_oe, irq}), 32'd0);
    rst_n = 1'b1;
    peek(2'd0, 32'd0, "R1 frame after reset");

    // R4: zero speed ignores the frame write
    wr(2'd0, rd_cmd(PHY_AT, 5'd2));
    repeat (4) @(negedge clk);
    peek(2'd0, 32'd0, "R4 zero speed ignored");
    check(mdc === 1'b0, "R4 mdc idle", 32'(mdc), 32'd0);

    // R7 R8: read present PHY at speed 2, mask off
    wr(2'd3, 32'd2 << 1);
    wr(2'd0, rd_cmd(PHY_AT, 5'd2));
    repeat (20) @(negedge clk);
    wr(2'd0, 32'h5000_0000);  // R5: ignored while busy
    peek(2'd0, rd_cmd(PHY_AT, 5'd2), "R5 frame unchanged while busy");
    wait_idle();
    peek(2'd0, rd_cmd(PHY_AT, 5'd2) | 32'h1236, "R7 read data");
    peek(2'd1, 32'd1, "R8 event set");
    check(irq === 1'b0, "R10 masked irq low", 32'(irq), 32'd0);

    // R9 clear rules
    wr(2'd1, 32'd0);
    peek(2'd1, 32'd1, "R9 write zero keeps");
    wr(2'd1, 32'hFFFF_FFFF);
    peek(2'd1, 32'd0, "R9 write ones clears");

    // R6 R10 R11: write command at speed 3, speed changed mid-frame
    wr(2'd2, 32'd1);
    wr(2'd3, 32'd3 << 1);
    wr(2'd0, 32'h5002_0000 | (32'(PHY_AT) << 23) | 32'hA5C3);
    repeat (30) @(negedge clk);
    wr(2'd3, 32'd1 << 1);
    wait_idle();
    check(irq === 1'b1, "R10 irq on completion", 32'(irq), 32'd1);
    peek(2'd0, 32'h5002_0000 | (32'(PHY_AT) << 23) | 32'hA5C3, "R6 write frame kept");
    wr(2'd1, 32'd1);
    check(irq === 1'b0, "R10 irq cleared", 32'(irq), 32'd0);

    // R7 absent PHY at speed 1
    wr(2'd0, rd_cmd(5'd7, 5'd1));
    wait_idle();
    peek(2'd0, rd_cmd(5'd7, 5'd1) | 32'hFFFF, "R7 absent phy");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule